// File: doc/BRIEF.md
# Tiled Crosspoint Route Allocator

This block is the control side of a large analog switch made from several 16-input, 8-output crosspoint tiles. Global inputs are spread across the tiles. Tile `t` carries global inputs `16*t` to `16*t+15`. Output `o` of every tile is wire-ORed onto one shared global output `o`. A route request names a global input, a global output and a channel grouping. The grouping is single-ended (one channel), paired (two channels, for differential or luminance/chroma video) or three-component (three channels, for component video). The block turns each request into a short series of tile configuration writes, followed by one common update strobe.

An internal shadow table records which tile currently drives each global output. Before a new tile is enabled on an output, the block disables the tile that drives it now. This keeps at most one driver on each wire-ORed line. Requests that would split a channel group across a tile edge or past the last output are rejected, and so are requests whose indices are out of range. While a write series runs, `busy` is high and new requests are ignored.

Top module: `tile_route_alloc`

## Requirements
- R1: After a synchronous reset, `busy`, `cfg_we`, `cfg_update` and `req_err` are low and the shadow table is empty. The first route to any output therefore emits no disable write.
- R2: A legal request sampled with `req_valid` high while `busy` is low is accepted. `busy` is high from the next cycle up to, but not including, the update cycle. The first write appears in the second cycle after the accepting edge, and the writes then follow one per cycle.
- R3: A write names the tile in `cfg_tile`, the output in `cfg_addr` and a 5-bit word in `cfg_data`. Bit 4 of the word is the enable and bits 3:0 are the local input select. For an enable, the tile is the global input divided by 16 and the select is the global input modulo 16.
- R4: `req_mode` encodes 1 as single, 2 as paired and 3 as three-component. Channel k, counted from 0, routes output `req_out+k` from local select `(req_in mod 16)+k` on the same tile, in ascending k.
- R5: If an output is currently enabled on a different tile, a disable write (`cfg_data` = 0) to that old tile comes immediately before the enable write. No disable is written when the output is unrouted or already on the same tile.
- R6: At no time are two tiles enabled on the same output.
- R7: Exactly one `cfg_update` pulse follows each accepted request, in the cycle after the last write, with `busy` low in that cycle. No other update, write or error appears while idle.
- R8: A request is rejected if any of these holds: the mode is 0, the input is at least `16*N_TILES`, `req_in mod 16` or `req_out` is not a multiple of the mode, or the group would run past local input 15 or output 7. A rejected request pulses `req_err` for one cycle after the edge, with no writes and no busy.
- R9: Requests presented while `busy` is high are ignored. They cause no writes and leave the shadow table unchanged.
- R10: Routing one input to further outputs never disables or rewrites the outputs it already feeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Route request present |
| req_in | input | 7 | Global input index |
| req_out | input | 3 | Global output index (first of group) |
| req_mode | input | 2 | Channel grouping: 1, 2 or 3 |
| busy | output | 1 | Write series in progress; requests ignored |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| cfg_we | output | 1 | Tile configuration write strobe |
| cfg_tile | output | $clog2(N_TILES) | Target tile of the write |
| cfg_addr | output | 3 | Tile output being written |
| cfg_data | output | 5 | Bit 4 enable, bits 3:0 local input select |
| cfg_update | output | 1 | Common update strobe for all tiles |

## Verification
The assertions assume that the tiles change only through this block's own writes, so that the driver map the checker rebuilds from `cfg_we` traffic matches the hardware. They also assume that reset is applied before any request. The stimulus keeps to this: reset is released before the first request, and every input change happens at the falling edge. Requests are also held high throughout some write series, to show that they are ignored rather than queued.

// File: rtl/xroute_pkg.sv
package xroute_pkg;
  localparam int TILE_INS  = 16;
  localparam int TILE_OUTS = 8;
  localparam int MAX_TILES = 8;
  localparam int SEL_W     = $clog2(TILE_INS);
  localparam int GOUT_W    = $clog2(TILE_OUTS);
  localparam int GIN_W     = $clog2(TILE_INS * MAX_TILES);
  localparam int DATA_W    = SEL_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIS  = 2'd1,
    ST_EN   = 2'd2,
    ST_UPD  = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } cfg_word_t;
endpackage

// File: rtl/xroute_req_check.sv
module xroute_req_check
  import xroute_pkg::*;
#(
  parameter int N_TILES = 4,
  localparam int TILE_W = $clog2(N_TILES)
) (
  input  logic [GIN_W-1:0]  in_idx,
  input  logic [GOUT_W-1:0] out_idx,
  input  logic [1:0]        mode,
  output logic              legal,
  output logic [TILE_W-1:0] tile,
  output logic [SEL_W-1:0]  local_sel
);
  localparam int HI_W = GIN_W - SEL_W;

  logic [HI_W-1:0] hi;
  logic            range_ok;
  logic            group_ok;

  assign hi        = in_idx[GIN_W-1:SEL_W];
  assign local_sel = in_idx[SEL_W-1:0];
  assign tile      = hi[TILE_W-1:0];
  assign range_ok  = (int'(hi) < N_TILES);

  always_comb begin
    case (mode)
      2'd1:    group_ok = 1'b1;
      2'd2:    group_ok = !local_sel[0] && !out_idx[0];
      2'd3:    group_ok = (local_sel inside {4'd0, 4'd3, 4'd6, 4'd9, 4'd12}) &&
                          (out_idx inside {3'd0, 3'd3});
      default: group_ok = 1'b0;
    endcase
  end

  assign legal = range_ok && group_ok;
endmodule

// File: rtl/xroute_shadow.sv
module xroute_shadow
  import xroute_pkg::*;
#(
  parameter int TILE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GOUT_W-1:0] rd_addr,
  output logic              rd_en,
  output logic [TILE_W-1:0] rd_tile,
  input  logic              wr_en,
  input  logic [GOUT_W-1:0] wr_addr,
  input  logic [TILE_W-1:0] wr_tile
);
  logic              ent_en   [TILE_OUTS];
  logic [TILE_W-1:0] ent_tile [TILE_OUTS];

  for (genvar g = 0; g < TILE_OUTS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_en[g]   <= 1'b0;
        ent_tile[g] <= '0;
      end else if (wr_en && wr_addr == GOUT_W'(g)) begin
        ent_en[g]   <= 1'b1;
        ent_tile[g] <= wr_tile;
      end
    end
  end

  assign rd_en   = ent_en[rd_addr];
  assign rd_tile = ent_tile[rd_addr];
endmodule

// File: rtl/xroute_seq.sv
module xroute_seq
  import xroute_pkg::*;
#(
  parameter int N_TILES = 4,
  localparam int TILE_W = $clog2(N_TILES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              chk_legal,
  input  logic [TILE_W-1:0] chk_tile,
  input  logic [SEL_W-1:0]  chk_sel,
  input  logic [GOUT_W-1:0] req_out,
  input  logic [1:0]        req_mode,
  output logic [GOUT_W-1:0] sh_addr,
  input  logic              sh_en,
  input  logic [TILE_W-1:0] sh_tile,
  output logic              sh_we,
  output logic [TILE_W-1:0] sh_wtile,
  output logic              busy,
  output logic              req_err,
  output logic              cfg_we,
  output logic [TILE_W-1:0] cfg_tile,
  output logic [GOUT_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_update
);
  seq_st_t           st;
  logic [1:0]        mode_q;
  logic [1:0]        k_q;
  logic [TILE_W-1:0] tile_q;
  logic [SEL_W-1:0]  sel_q;
  logic [GOUT_W-1:0] out_q;

  logic [GOUT_W-1:0] cur_out;
  logic [SEL_W-1:0]  cur_sel;
  logic              need_dis;
  logic              last_ch;
  cfg_word_t         en_word;

  assign cur_out  = out_q + GOUT_W'(k_q);
  assign cur_sel  = sel_q + SEL_W'(k_q);
  assign need_dis = sh_en && (sh_tile != tile_q);
  assign last_ch  = (k_q + 2'd1) == mode_q;
  assign en_word  = '{en: 1'b1, sel: cur_sel};

  assign sh_addr  = cur_out;
  assign sh_wtile = tile_q;
  assign sh_we    = (st == ST_EN) || (st == ST_DIS && !need_dis);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      req_err    <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_update <= 1'b0;
      cfg_tile   <= '0;
      cfg_addr   <= '0;
      cfg_data   <= '0;
      mode_q     <= '0;
      k_q        <= '0;
      tile_q     <= '0;
      sel_q      <= '0;
      out_q      <= '0;
    end else begin
      cfg_we     <= 1'b0;
      cfg_update <= 1'b0;
      req_err    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (chk_legal) begin
              mode_q <= req_mode;
              tile_q <= chk_tile;
              sel_q  <= chk_sel;
              out_q  <= req_out;
              k_q    <= '0;
              busy   <= 1'b1;
              st     <= ST_DIS;
            end else begin
              req_err <= 1'b1;
            end
          end
        end
        ST_DIS, ST_EN: begin
          cfg_we   <= 1'b1;
          cfg_addr <= cur_out;
          if (st == ST_DIS && need_dis) begin
            cfg_tile <= sh_tile;
            cfg_data <= '0;
            st       <= ST_EN;
          end else begin
            cfg_tile <= tile_q;
            cfg_data <= en_word;
            if (last_ch) begin
              st <= ST_UPD;
            end else begin
              k_q <= k_q + 2'd1;
              st  <= ST_DIS;
            end
          end
        end
        ST_UPD: begin
          cfg_update <= 1'b1;
          busy       <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_route_alloc.sv
module tile_route_alloc
  import xroute_pkg::*;
#(
  parameter int N_TILES = 4,
  localparam int TILE_W = $clog2(N_TILES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [6:0]        req_in,
  input  logic [2:0]        req_out,
  input  logic [1:0]        req_mode,
  output logic              busy,
  output logic              req_err,
  output logic              cfg_we,
  output logic [TILE_W-1:0] cfg_tile,
  output logic [2:0]        cfg_addr,
  output logic [4:0]        cfg_data,
  output logic              cfg_update
);
  logic              chk_legal;
  logic [TILE_W-1:0] chk_tile;
  logic [SEL_W-1:0]  chk_sel;
  logic [GOUT_W-1:0] sh_addr;
  logic              sh_en;
  logic [TILE_W-1:0] sh_tile;
  logic              sh_we;
  logic [TILE_W-1:0] sh_wtile;

  xroute_req_check #(.N_TILES(N_TILES)) u_check (
    .in_idx    (req_in),
    .out_idx   (req_out),
    .mode      (req_mode),
    .legal     (chk_legal),
    .tile      (chk_tile),
    .local_sel (chk_sel)
  );

  xroute_shadow #(.TILE_W(TILE_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (sh_addr),
    .rd_en   (sh_en),
    .rd_tile (sh_tile),
    .wr_en   (sh_we),
    .wr_addr (sh_addr),
    .wr_tile (sh_wtile)
  );

  xroute_seq #(.N_TILES(N_TILES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .chk_legal  (chk_legal),
    .chk_tile   (chk_tile),
    .chk_sel    (chk_sel),
    .req_out    (req_out),
    .req_mode   (req_mode),
    .sh_addr    (sh_addr),
    .sh_en      (sh_en),
    .sh_tile    (sh_tile),
    .sh_we      (sh_we),
    .sh_wtile   (sh_wtile),
    .busy       (busy),
    .req_err    (req_err),
    .cfg_we     (cfg_we),
    .cfg_tile   (cfg_tile),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data),
    .cfg_update (cfg_update)
  );
endmodule

// File: rtl/xroute_checker.sv
module xroute_checker #(
  parameter int N_TILES = 4,
  localparam int TILE_W = $clog2(N_TILES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              req_err,
  input logic              cfg_we,
  input logic [TILE_W-1:0] cfg_tile,
  input logic [2:0]        cfg_addr,
  input logic [4:0]        cfg_data,
  input logic              cfg_update
);
  logic [N_TILES-1:0] drv [8];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) drv[i] <= '0;
    end else if (cfg_we) begin
      drv[cfg_addr][cfg_tile] <= cfg_data[4];
    end
  end

  for (genvar o = 0; o < 8; o++) begin : g_out
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
      $countones(drv[o]) <= 1) else $error("two drivers on output %0d", o); // R6
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> busy) else $error("write outside busy"); // R2
  AST_UPD_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    cfg_update |-> (!busy && $past(cfg_we))) else $error("update not after write"); // R7
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_update |=> !cfg_update) else $error("double update"); // R7
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cfg_update) else $error("busy fell without update"); // R7
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!busy && !cfg_we && $past(req_valid))) else $error("bad reject"); // R8
  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_data[4]) |-> (cfg_data[3:0] == 4'd0)) else $error("disable word nonzero"); // R5
endmodule

bind tile_route_alloc xroute_checker #(.N_TILES(N_TILES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .req_err    (req_err),
  .cfg_we     (cfg_we),
  .cfg_tile   (cfg_tile),
  .cfg_addr   (cfg_addr),
  .cfg_data   (cfg_data),
  .cfg_update (cfg_update)
);

// File: tb/sim_tile_route_alloc.sv
`timescale 1ns/1ps
module sim_tile_route_alloc;
  localparam int NT = 4;
  localparam int TW = $clog2(NT);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [6:0]    req_in = '0;
  logic [2:0]    req_out = '0;
  logic [1:0]    req_mode = '0;
  logic          busy, req_err, cfg_we, cfg_update;
  logic [TW-1:0] cfg_tile;
  logic [2:0]    cfg_addr;
  logic [4:0]    cfg_data;

  always #4 clk = ~clk;

  tile_route_alloc #(.N_TILES(NT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
    .req_out(req_out), .req_mode(req_mode), .busy(busy), .req_err(req_err),
    .cfg_we(cfg_we), .cfg_tile(cfg_tile), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_update(cfg_update)
  );

  typedef struct {
    bit busy; bit we; int tile; int addr; int data; bit upd; bit err;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   errors = 0;
  bit   m_en [8];
  int   m_tile [8];
  int   cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual run length %0d, expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit legal(int gin, int gout, int mode);
    int loc;
    if (mode < 1 || mode > 3) return 0;
    if (gin >= NT * 16) return 0;
    loc = gin % 16;
    if (loc % mode != 0 || loc + mode > 16) return 0;
    if (gout % mode != 0 || gout + mode > 8) return 0;
    return 1;
  endfunction

  task automatic push(bit b, bit we, int t, int a, int d, bit u, bit e, string tag);
    exp_t x;
    x.busy = b; x.we = we; x.tile = t; x.addr = a; x.data = d;
    x.upd = u; x.err = e; x.tag = tag;
    expq.push_back(x);
  endtask

  task automatic step();
    exp_t x;
    bit   bad;
    @(posedge clk);
    @(negedge clk);
    if (expq.size() > 0) x = expq.pop_front();
    else begin
      x.busy = 0; x.we = 0; x.tile = 0; x.addr = 0; x.data = 0;
      x.upd = 0; x.err = 0; x.tag = "R7 idle";
    end
    checks++;
    bad = (busy !== x.busy) || (cfg_we !== x.we) || (cfg_update !== x.upd) ||
          (req_err !== x.err);
    if (x.we && cfg_we === 1'b1)
      bad = bad || (int'(cfg_tile) != x.tile) || (int'(cfg_addr) != x.addr) ||
            (int'(cfg_data) != x.data);
    if (bad) begin
      errors++;
      $display("FAIL %s: actual busy=%b we=%b tile=%0d addr=%0d data=%h upd=%b err=%b, expected busy=%b we=%b tile=%0d addr=%0d data=%h upd=%b err=%b",
               x.tag, busy, cfg_we, cfg_tile, cfg_addr, cfg_data, cfg_update, req_err,
               x.busy, x.we, x.tile, x.addr, x.data, x.upd, x.err);
    end
  endtask

  task automatic submit(int gin, int gout, int mode, bit spam, string tag);
    req_valid = 1'b1;
    req_in    = 7'(gin);
    req_out   = 3'(gout);
    req_mode  = 2'(mode);
    if (legal(gin, gout, mode)) begin
      push(1, 0, 0, 0, 0, 0, 0, {tag, " R2 accept"});
      for (int k = 0; k < mode; k++) begin
        int o = gout + k;
        int t = gin / 16;
        int s = gin % 16 + k;
        if (m_en[o] && m_tile[o] != t)
          push(1, 1, m_tile[o], o, 0, 0, 0, {tag, " R5 disable"});
        push(1, 1, t, o, 16 + s, 0, 0, {tag, " R3 R4 enable"});
        m_en[o] = 1;
        m_tile[o] = t;
      end
      push(0, 0, 0, 0, 0, 1, 0, {tag, " R7 update"});
    end else begin
      push(0, 0, 0, 0, 0, 0, 1, {tag, " R8 reject"});
    end
    step();
    if (spam) begin
      req_in = 7'd9; req_out = 3'd7; req_mode = 2'd1;
    end else begin
      req_valid = 1'b0;
    end
    while (expq.size() > 0) step();
    req_valid = 1'b0;
    step();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_tile[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || cfg_we !== 1'b0 || cfg_update !== 1'b0 || req_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual busy=%b we=%b upd=%b err=%b, expected all 0",
               busy, cfg_we, cfg_update, req_err);
    end
    rst = 1'b0;
    step();
    step();

    submit(5, 2, 1, 0, "R1 R3 first route");
    submit(37, 2, 1, 0, "R5 tile change");
    submit(37, 3, 1, 0, "R10 fanout");
    submit(40, 2, 1, 0, "R5 same tile");
    submit(18, 4, 2, 0, "R4 pair");
    submit(3, 0, 3, 0, "R4 triple");
    submit(30, 6, 2, 0, "R4 pair top edge");
    submit(60, 7, 1, 1, "R9 busy spam");
    submit(12, 3, 3, 0, "R4 triple last");
    submit(10, 1, 0, 0, "R8 mode0");
    submit(64, 0, 1, 0, "R8 input range");
    submit(127, 0, 1, 0, "R8 input max");
    submit(19, 2, 2, 0, "R8 pair input align");
    submit(18, 5, 2, 0, "R8 pair output align");
    submit(15, 0, 3, 0, "R8 triple input edge");
    submit(14, 0, 3, 0, "R8 triple input align");
    submit(0, 6, 3, 0, "R8 triple output edge");
    submit(9, 7, 1, 0, "R9 R10 after spam");
    submit(37, 7, 1, 0, "R5 tile change back");
    repeat (3) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule